// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer for a processor subsystem. Software sets it up through four 32-bit registers on a simple strobe bus and must then keep restarting it. If software stops writing the restart word, a down-counter clocked through a selectable prescaler reaches zero. The block then flags the expiry in a sticky status bit and can raise a level interrupt, a reset pulse of programmable length, or both.

Both configuration registers reject any write whose key field does not hold the expected value. The restart register reacts to one exact 32-bit word and to nothing else. A stray store therefore cannot reprogram or feed the watchdog. The reload count is built from a 12-bit restart value placed above `LOW_W` low bits that are all set. A small restart value still gives a long interval.

Top module: `keyed_wdog`

## Requirements
- R1: Register reads (word index `bus_addr[3:2]`: 0 mode, 1 control, 2 restart, 3 status) return the stored fields on `bus_rdata` one cycle after the `bus_rd` strobe. Key bits and unused bits read as zero. Mode layout: bit 0 run enable, bit 1 reset enable, bit 2 interrupt enable, bits [5:4] pulse length code. Control layout: bits [13:2] restart value, bits [1:0] prescale select. Status layout: bit 0 expired. The restart register reads as zero.
- R2: After reset both outputs are low, mode reads 0, control reads 0x3FFF (restart value 0xFFF, select 3) and status reads 0.
- R3: A mode write takes effect only when bits [23:12] of the write data equal 0xABC. Any other write to the mode register leaves it unchanged.
- R4: A control write takes effect only when bits [25:14] of the write data equal 0x248 (the word 0x00920000). Any other write to the control register leaves it unchanged.
- R5: Only the exact word 0x00001999 written to the restart register reloads the counter. The counter is loaded with {restart value, LOW_W ones}, and the prescaler and the expired flag are cleared. Any other word has no effect.
- R6: Prescale select 0, 1, 2 and 3 gives one counter step every 8, 64, 512 and 4096 clock cycles.
- R7: While enabled, the expired flag sets exactly N*D cycles after the edge that captured the restart write, where N is the reload count and D the prescale divisor. The counter then stays at zero.
- R8: The expired flag stays set until a valid restart. `irq_o` is high while the flag is set and the interrupt enable is on.
- R9: With reset enable on, `rst_o` goes high in the cycle the flag sets and stays high for 2, 4, 8 or 16 cycles for length codes 0 to 3.
- R10: Clearing the run enable freezes the count and clears the prescaler. Setting the enable again resumes from the frozen count with a fresh prescale period.
- R11: With the interrupt enable off, an expiry sets the status bit but `irq_o` stays low. Turning the enable on or off while the flag is set moves `irq_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 2 | Word index, byte address bits [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt on expiry |
| rst_o | output | 1 | Reset pulse on expiry |

## Verification
Read data is due one cycle after the read strobe. A register write shows its effect on the outputs one cycle after it is driven. An expiry moves the outputs N*D+1 cycles after the restart write is driven, and a reset pulse falls 2<<code cycles after it rises. The driver records the cycle in which it drives each access. From that cycle it computes every due cycle by this arithmetic and queues an expected value tagged with its due cycle. The monitor compares each queued value only at the falling edge of the cycle it is due. Around each edge the monitor checks the value just before it and just after it, so a design that is off by one cycle fails.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int          KEY_W        = 12;
    localparam int          MODE_KEY_LSB = 12;
    localparam int          CTL_KEY_LSB  = 14;
    localparam logic [11:0] MODE_KEY     = 12'hABC;
    localparam logic [11:0] CTL_KEY      = 12'h248;
    localparam logic [31:0] FEED_WORD    = 32'h0000_1999;
    localparam int          CRV_W        = 12;
    localparam int          SEL_W        = 2;
    localparam int          LEN_W        = 2;

    typedef enum logic [1:0] {
        REG_MODE = 2'd0,
        REG_CTL  = 2'd1,
        REG_FEED = 2'd2,
        REG_STAT = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic             run_en;
        logic             rst_en;
        logic             irq_en;
        logic [LEN_W-1:0] plen;
        logic [CRV_W-1:0] crv;
        logic [SEL_W-1:0] sel;
    } wdog_cfg_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:2]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        expired_i,
    output wdog_cfg_t   cfg_o,
    output logic        feed_o,
    output logic [31:0] bus_rdata
);
    typedef struct packed {
        wdog_cfg_t   cfg;
        logic [31:0] rdata;
    } regs_state_t;

    regs_state_t st_d, st_q;
    reg_idx_e    idx;
    logic        mode_key_ok, ctl_key_ok;
    logic [31:0] rd_mux;

    always_comb begin
        idx         = reg_idx_e'(bus_addr);
        mode_key_ok = bus_wdata[MODE_KEY_LSB +: KEY_W] == MODE_KEY;
        ctl_key_ok  = bus_wdata[CTL_KEY_LSB +: KEY_W] == CTL_KEY;
        st_d        = st_q;
        feed_o      = 1'b0;

        if (bus_wr) begin
            unique case (idx)
                REG_MODE: if (mode_key_ok) begin
                    st_d.cfg.run_en = bus_wdata[0];
                    st_d.cfg.rst_en = bus_wdata[1];
                    st_d.cfg.irq_en = bus_wdata[2];
                    st_d.cfg.plen   = bus_wdata[5:4];
                end
                REG_CTL: if (ctl_key_ok) begin
                    st_d.cfg.crv = bus_wdata[CRV_W+1:2];
                    st_d.cfg.sel = bus_wdata[SEL_W-1:0];
                end
                REG_FEED: feed_o = bus_wdata == FEED_WORD;
                default: ;
            endcase
        end

        unique case (idx)
            REG_MODE: rd_mux = {26'd0, st_q.cfg.plen, 1'b0, st_q.cfg.irq_en,
                                st_q.cfg.rst_en, st_q.cfg.run_en};
            REG_CTL:  rd_mux = {18'd0, st_q.cfg.crv, st_q.cfg.sel};
            REG_STAT: rd_mux = {31'd0, expired_i};
            default:  rd_mux = 32'd0;
        endcase
        if (bus_rd) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg.run_en <= 1'b0;
            st_q.cfg.rst_en <= 1'b0;
            st_q.cfg.irq_en <= 1'b0;
            st_q.cfg.plen   <= '0;
            st_q.cfg.crv    <= '1;
            st_q.cfg.sel    <= '1;
            st_q.rdata      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o     = st_q.cfg;
    assign bus_rdata = st_q.rdata;

    // R3: an unkeyed mode write leaves the mode fields untouched
    p_mode_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && bus_wdata[23:12] != 12'hABC)
        |=> ($stable(cfg_o.run_en) && $stable(cfg_o.rst_en) &&
             $stable(cfg_o.irq_en) && $stable(cfg_o.plen)));

    // R4: an unkeyed control write leaves the control fields untouched
    p_ctl_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && bus_wdata[25:14] != 12'h248)
        |=> ($stable(cfg_o.crv) && $stable(cfg_o.sel)));

    // R1: read data moves only after a read strobe
    p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int BASE_SHIFT = 3,
    parameter int STEP_SHIFT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       clear_i,
    input  logic [1:0] sel_i,
    output logic       tick_o
);
    localparam int NUM_SEL = 4;
    localparam int PSC_W   = BASE_SHIFT + (NUM_SEL - 1) * STEP_SHIFT;
    localparam logic [PSC_W-1:0] PSC_ONE = {{(PSC_W-1){1'b0}}, 1'b1};

    logic [PSC_W-1:0] last_cnt [NUM_SEL];

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_term
        assign last_cnt[g] = (PSC_ONE << (BASE_SHIFT + g * STEP_SHIFT)) - PSC_ONE;
    end

    logic [PSC_W-1:0] psc_d, psc_q;

    always_comb begin
        tick_o = run_i && (psc_q == last_cnt[sel_i]);
        if (!run_i || clear_i || tick_o) psc_d = '0;
        else                             psc_d = psc_q + PSC_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
    end

    // R10: no step can follow a cycle with the watchdog stopped
    p_idle_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !tick_o);

    // R6: steps are never back to back (smallest divisor is above one)
    p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
    import wdog_pkg::*;
#(
    parameter int LOW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             feed_i,
    input  logic [CRV_W-1:0] crv_i,
    input  logic             rst_en_i,
    input  logic             irq_en_i,
    input  logic [LEN_W-1:0] plen_i,
    output logic             expired_o,
    output logic             irq_o,
    output logic             rst_o
);
    localparam int CNT_W = CRV_W + LOW_W;
    localparam int PLS_W = (1 << LEN_W) + 1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [PLS_W-1:0] PLS_ONE = {{(PLS_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             expired;
        logic [PLS_W-1:0] pulse;
    } cd_state_t;

    cd_state_t st_d, st_q;
    logic      fire;

    always_comb begin
        st_d = st_q;
        fire = !feed_i && tick_i && (st_q.cnt == CNT_ONE);

        if (feed_i) begin
            st_d.cnt     = {crv_i, {LOW_W{1'b1}}};
            st_d.expired = 1'b0;
        end else if (tick_i && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_ONE;
            if (fire) st_d.expired = 1'b1;
        end

        if (fire && rst_en_i)
            st_d.pulse = PLS_ONE << ({1'b0, plen_i} + {{LEN_W{1'b0}}, 1'b1});
        else if (st_q.pulse != '0)
            st_d.pulse = st_q.pulse - PLS_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt     <= '1;
            st_q.expired <= 1'b0;
            st_q.pulse   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired_o = st_q.expired;
    assign irq_o     = st_q.expired && irq_en_i;
    assign rst_o     = st_q.pulse != '0;

    // R8: the expired flag is sticky until a valid restart
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !feed_i) |=> expired_o);

    // R5: a valid restart always clears the expired flag
    p_feed_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        feed_i |=> !expired_o);

    // R10: without a step or a restart the count does not move
    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !feed_i) |=> $stable(st_q.cnt));

    // R7: a zero count only exists after an expiry
    p_zero_flagged_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) |-> expired_o);

    // R9: the reset pulse starts in the cycle the flag sets
    p_pulse_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!expired_o && !feed_i && tick_i && st_q.cnt == CNT_ONE && rst_en_i)
        |=> (rst_o && expired_o));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import wdog_pkg::*;
#(
    parameter int LOW_W      = 12,
    parameter int BASE_SHIFT = 3,
    parameter int STEP_SHIFT = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:2]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o,
    output logic        rst_o
);
    wdog_cfg_t cfg;
    logic      feed, tick, expired;

    wdog_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .expired_i (expired),
        .cfg_o     (cfg),
        .feed_o    (feed),
        .bus_rdata (bus_rdata)
    );

    wdog_prescaler #(
        .BASE_SHIFT (BASE_SHIFT),
        .STEP_SHIFT (STEP_SHIFT)
    ) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (cfg.run_en),
        .clear_i (feed),
        .sel_i   (cfg.sel),
        .tick_o  (tick)
    );

    wdog_countdown #(
        .LOW_W (LOW_W)
    ) u_cd (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .feed_i    (feed),
        .crv_i     (cfg.crv),
        .rst_en_i  (cfg.rst_en),
        .irq_en_i  (cfg.irq_en),
        .plen_i    (cfg.plen),
        .expired_o (expired),
        .irq_o     (irq_o),
        .rst_o     (rst_o)
    );
endmodule

// File: tb/test_keyed_wdog.sv
`timescale 1ns/1ps
module test_keyed_wdog;
    localparam int LOW_W = 4;
    localparam int NLOW  = (1 << LOW_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:2]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, rst_o;

    keyed_wdog #(.LOW_W(LOW_W)) i_keyed_wdog (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .rst_o(rst_o)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        int          kind;   // 0 rdata, 1 irq_o, 2 rst_o
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    int    checks = 0, failures = 0;
    bit    done = 1'b0;

    function automatic logic [31:0] observe(int kind);
        case (kind)
            0:       return bus_rdata;
            1:       return {31'd0, irq_o};
            default: return {31'd0, rst_o};
        endcase
    endfunction

    // monitor: compare each queued item in its due cycle
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].due <= cyc) begin
                    checks++;
                    if (sb[i].due < cyc || observe(sb[i].kind) !== sb[i].exp) begin
                        failures++;
                        $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                                 sb[i].req, sb[i].kind, sb[i].due,
                                 observe(sb[i].kind), sb[i].exp);
                    end
                    sb.delete(i);
                end
            end
        end
    end

    task automatic expect_at(int due, int kind, logic [31:0] e, string r);
        item_t it;
        it.due = due; it.kind = kind; it.exp = e; it.req = r;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, output int c);
        @(negedge clk);
        c = cyc;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string r);
        @(negedge clk);
        expect_at(cyc + 1, 0, e, r);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
    endtask

    // level output low up to and including the last cycle, high right after
    task automatic expect_edge(int c, int span, int kind, string r);
        expect_at(c + span, kind, 32'd0, r);
        expect_at(c + span + 1, kind, 32'd1, r);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        int c, d, e, k;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        expect_at(cyc + 1, 1, 32'd0, "R2 irq");
        expect_at(cyc + 1, 2, 32'd0, "R2 rst");
        rd(2'd0, 32'h0, "R2 mode");
        rd(2'd1, 32'h3FFF, "R2 ctl");
        rd(2'd3, 32'h0, "R2 status");
        drain();

        // R3: mode key
        wr(2'd0, 32'h00ABD036, c);
        rd(2'd0, 32'h0, "R3 bad key ignored");
        wr(2'd0, 32'h5AABC036, c);
        rd(2'd0, 32'h36, "R3 R1 keyed write, key bits read zero");

        // R4: control key
        wr(2'd1, 32'h00930005, c);
        rd(2'd1, 32'h3FFF, "R4 bad key ignored");
        wr(2'd1, 32'h00920000, c);
        rd(2'd1, 32'h0, "R4 keyed write");
        rd(2'd2, 32'h0, "R1 restart reads zero");
        drain();

        // R7 R8: expiry with interrupt, select 0, restart value 0
        wr(2'd0, 32'h00ABC005, c);
        wr(2'd2, 32'h00001999, c);
        expect_edge(c, NLOW * 8, 1, "R7 irq at expiry");
        drain();
        rd(2'd3, 32'h1, "R8 status set");
        wr(2'd2, 32'h00001998, c);
        wr(2'd2, 32'h00011999, c);
        expect_at(cyc + 3, 1, 32'd1, "R5 wrong word no restart");
        rd(2'd3, 32'h1, "R5 R8 status still set");
        drain();
        wr(2'd2, 32'h00001999, c);
        expect_at(c + 1, 1, 32'd0, "R5 restart clears irq");
        rd(2'd3, 32'h0, "R5 status cleared");
        drain();

        // R5: restart value forms the upper bits of the count
        wr(2'd1, 32'h00920004, c);
        wr(2'd2, 32'h00001999, c);
        expect_edge(c, ((1 << LOW_W) + NLOW) * 8, 1, "R5 reload from restart value");
        drain();

        // R6: prescale selects 1..3
        for (int s = 1; s < 4; s++) begin
            wr(2'd1, 32'h00920000 | s, c);
            wr(2'd2, 32'h00001999, c);
            expect_edge(c, NLOW << (3 + 3 * s), 1, "R6 prescale divisor");
            drain();
        end

        // R9 R11: reset pulse lengths with interrupt masked
        wr(2'd1, 32'h00920000, c);
        for (int len = 0; len < 4; len++) begin
            wr(2'd0, 32'h00ABC003 | (len << 4), c);
            wr(2'd2, 32'h00001999, c);
            expect_edge(c, NLOW * 8, 2, "R9 pulse rises at expiry");
            expect_at(c + NLOW * 8 + 1, 1, 32'd0, "R11 irq masked");
            expect_at(c + NLOW * 8 + (2 << len), 2, 32'd1, "R9 pulse last cycle");
            expect_at(c + NLOW * 8 + (2 << len) + 1, 2, 32'd0, "R9 pulse ends");
            drain();
            rd(2'd3, 32'h1, "R11 status set while masked");
            drain();
        end
        wr(2'd0, 32'h00ABC005, c);
        expect_at(c + 1, 1, 32'd1, "R11 unmask raises irq");
        drain();
        wr(2'd0, 32'h00ABC001, c);
        expect_at(c + 1, 1, 32'd0, "R11 mask drops irq");
        drain();

        // R10: stop, hold, resume
        wr(2'd0, 32'h00ABC005, c);
        wr(2'd2, 32'h00001999, c);
        while (cyc < c + 43) @(negedge clk);
        wr(2'd0, 32'h00ABC004, d);
        k = (d - c) / 8;
        expect_at(d + 100, 1, 32'd0, "R10 no expiry while stopped");
        drain();
        rd(2'd3, 32'h0, "R10 status clear while stopped");
        wr(2'd0, 32'h00ABC005, e);
        expect_edge(e, (NLOW - k) * 8, 1, "R10 resume from frozen count");
        drain();

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            summary();
            $finish;
        end
    end
endmodule